// File: doc/BRIEF.md
# Lane Receiver Initialization Detector

This block is the receive-side start-up controller for one lane of a serial PHY that has a low-power signalling mode. After a reset it watches the decoded low-power line levels, and optionally a wake-pulse detector, and waits for the first sufficiently long qualifying condition. That condition marks the initialization period. After it, the lane is declared initialized. Any line activity before the qualifying condition is ignored. The threshold is a programmable cycle count, so one implementation covers protocol layers that need different minimum times. For example, 500 us at 50 MHz is 25000 cycles.

A static mode strap selects one of two procedures. In ordinary mode, the qualifying condition is the stop state, with both lines high. In wake mode, the qualifying condition is a long wake pulse, and it must be followed by a stop state with the wake detector low. In wake mode the block also sequences the receiver's differential termination. Termination is on while the lane is idle, off from the start of the wake pulse until initialization completes, and back on afterwards.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake. The strap and the threshold are expected to stay constant between resets.

Top module: `lane_rx_init_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to WAIT (`init_state` = 0). After that edge, `init_done` is 0 and `term_en` equals `mode_alt`.
- R2: In ordinary mode (`mode_alt` = 0), the lane reaches DONE at the clock edge that samples the (`init_cycles`+1)-th consecutive cycle of `line_p` = `line_n` = 1. One sample fewer leaves it in COUNTING (`init_state` = 1).
- R3: If the qualifying condition drops before the count expires, the block returns to WAIT at the next edge. A later qualification needs a full new run.
- R4: In ordinary mode, line states other than both-high, and any activity on `wake_det`, leave the block in WAIT.
- R5: In wake mode, `init_cycles`+1 consecutive samples of `wake_det` = 1 move the block to ARMED (`init_state` = 2). In ARMED, the first sample with both lines high and `wake_det` = 0 moves it to DONE.
- R6: In wake mode, `term_en` is 1 in WAIT and DONE and 0 in COUNTING and ARMED. In ordinary mode, `term_en` is always 0.
- R7: In wake mode, a stop state without a wake pulse does not leave WAIT.
- R8: Once DONE (`init_state` = 3) is reached, `init_done` stays 1 and the state stays DONE for any input until a reset.
- R9: `init_state` encodes WAIT = 0, COUNTING = 1, ARMED = 2, DONE = 3. `init_done` is 1 exactly in DONE.
- R10: With `init_cycles` = 0, a single qualifying sample completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_alt | input | 1 | Strap: 0 = ordinary stop-state mode, 1 = wake-pulse mode |
| line_p | input | 1 | Decoded low-power level of the positive line |
| line_n | input | 1 | Decoded low-power level of the negative line |
| wake_det | input | 1 | Wake-pulse detector output |
| init_cycles | input | 24 | Threshold; the condition must last this many cycles plus one |
| init_done | output | 1 | Sticky: lane initialized |
| term_en | output | 1 | Differential termination enable |
| init_state | output | 2 | Current state code |

## Verification
The assertions assume that `mode_alt` and `init_cycles` change only while `rst_n` is low. They also assume that the line and wake inputs are already synchronous to `clk`. The stimulus changes the strap and the threshold only inside a reset pulse. It drives every other input once per cycle, on the falling clock edge. The line and wake patterns include noise, short runs that end one cycle before expiry, and runs that just reach it.

// File: rtl/lane_init_pkg.sv
package lane_init_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ARMED = 2'd2,
    ST_DONE  = 2'd3
  } init_st_e;

  function automatic logic term_wanted(input logic alt, input init_st_e st);
    return alt && (st == ST_WAIT || st == ST_DONE);
  endfunction
endpackage

// File: rtl/lane_cond_decode.sv
module lane_cond_decode (
  input  logic mode_alt,
  input  logic line_p,
  input  logic line_n,
  input  logic wake_det,
  output logic qual_cond,
  output logic rest_ok
);
  logic stop_lvl;
  always_comb begin
    stop_lvl  = line_p & line_n;
    qual_cond = mode_alt ? wake_det : stop_lvl;
    rest_ok   = stop_lvl & ~wake_det;
  end
endmodule

// File: rtl/lane_qual_timer.sv
module lane_qual_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] thr,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = run && (cnt_q >= thr);
endmodule

// File: rtl/lane_init_fsm.sv
module lane_init_fsm
  import lane_init_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_alt,
  input  logic     qual_cond,
  input  logic     rest_ok,
  input  logic     hit,
  output logic     run,
  output init_st_e state
);
  init_st_e nxt;

  assign run = qual_cond && (state == ST_WAIT || state == ST_COUNT);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WAIT, ST_COUNT: begin
        if (!qual_cond)  nxt = ST_WAIT;
        else if (hit)    nxt = mode_alt ? ST_ARMED : ST_DONE;
        else             nxt = ST_COUNT;
      end
      ST_ARMED: if (rest_ok) nxt = ST_DONE;
      ST_DONE:  nxt = ST_DONE;
      default:  nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= nxt;
  end

  // R4 / R7: without the qualifying condition the block stays idle
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !qual_cond) |=> state == ST_WAIT);
  p_drop_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && !qual_cond) |=> state == ST_WAIT);
  p_armed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !rest_ok) |=> state == ST_ARMED);
  p_lp_no_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_alt |-> state != ST_ARMED);
endmodule

// File: rtl/lane_term_ctrl.sv
module lane_term_ctrl
  import lane_init_pkg::*;
(
  input  logic     mode_alt,
  input  init_st_e state,
  output logic     term_en
);
  assign term_en = term_wanted(mode_alt, state);
endmodule

// File: rtl/lane_rx_init_det.sv
module lane_rx_init_det
  import lane_init_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_alt,
  input  logic             line_p,
  input  logic             line_n,
  input  logic             wake_det,
  input  logic [CNT_W-1:0] init_cycles,
  output logic             init_done,
  output logic             term_en,
  output logic [1:0]       init_state
);
  logic     qual_cond, rest_ok, run, hit;
  init_st_e st;

  lane_cond_decode u_dec (
    .mode_alt(mode_alt), .line_p(line_p), .line_n(line_n),
    .wake_det(wake_det), .qual_cond(qual_cond), .rest_ok(rest_ok)
  );

  lane_qual_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .thr(init_cycles), .hit(hit)
  );

  lane_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt), .qual_cond(qual_cond),
    .rest_ok(rest_ok), .hit(hit), .run(run), .state(st)
  );

  lane_term_ctrl u_term (.mode_alt(mode_alt), .state(st), .term_en(term_en));

  assign init_done  = (st == ST_DONE);
  assign init_state = st;

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_term_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_state == 2'd1 || init_state == 2'd2) |-> !term_en);
  p_term_lp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_alt |-> !term_en);
  p_stable_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(init_state));
endmodule

// File: tb/sim_lane_rx_init_det.sv
module sim_lane_rx_init_det;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_alt = 1'b0;
  logic line_p = 1'b0, line_n = 1'b0, wake_det = 1'b0;
  logic [23:0] init_cycles = 24'd6;
  logic init_done, term_en;
  logic [1:0] init_state;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model
  int m_ph = 0;
  int m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_rx_init_det u0 (
    .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt), .line_p(line_p),
    .line_n(line_n), .wake_det(wake_det), .init_cycles(init_cycles),
    .init_done(init_done), .term_en(term_en), .init_state(init_state)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_ph = 0; m_run = 0;
    end else if (m_ph <= 1) begin
      if (mode_alt ? wake_det : (line_p && line_n)) begin
        m_run = m_run + 1;
        if (m_run > int'(init_cycles)) begin
          m_ph = mode_alt ? 2 : 3; m_run = 0;
        end else m_ph = 1;
      end else begin
        m_ph = 0; m_run = 0;
      end
    end else if (m_ph == 2) begin
      if (line_p && line_n && !wake_det) m_ph = 3;
    end
  end

  // compare every cycle (R9 encoding used throughout)
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (init_state !== 2'(m_ph) || init_done !== (m_ph == 3) ||
          term_en !== (mode_alt && (m_ph == 0 || m_ph == 3))) begin
        fails++;
        $display("FAIL %s R9 model: state=%0d done=%0b term=%0b expected state=%0d done=%0b term=%0b",
                 cur_req, init_state, init_done, term_en, m_ph, m_ph == 3,
                 mode_alt && (m_ph == 0 || m_ph == 3));
      end
    end
  end

  task automatic step(input logic p, input logic n, input logic w);
    line_p = p; line_n = n; wake_det = w;
    @(negedge clk);
  endtask

  task automatic expect_st(input string req, input int exp_st, input int exp_term);
    checks++;
    if (init_state !== 2'(exp_st) || term_en !== 1'(exp_term)) begin
      fails++;
      $display("FAIL %s: state=%0d term=%0b expected state=%0d term=%0b",
               req, init_state, term_en, exp_st, exp_term);
    end
  endtask

  task automatic do_reset(input logic alt, input int thr);
    rst_n = 1'b0; mode_alt = alt; init_cycles = 24'(thr);
    step(0, 0, 0); step(0, 0, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // R1 ordinary mode
    cur_req = "R1";
    do_reset(1'b0, 6);
    expect_st("R1", 0, 0);
    // R4 noise without stop
    cur_req = "R4";
    for (int i = 0; i < 40; i++) begin
      int v = $urandom_range(0, 2);
      step(v == 1, v == 2, 1'($urandom_range(0, 1)));
    end
    expect_st("R4", 0, 0);
    // R3 run one sample short, then drop
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(1, 1, 0);
    expect_st("R3", 1, 0);
    step(0, 1, 0);
    expect_st("R3", 0, 0);
    // R2 exact threshold
    cur_req = "R2";
    for (int i = 0; i < 6; i++) step(1, 1, 0);
    expect_st("R2", 1, 0);
    step(1, 1, 0);
    expect_st("R2", 3, 0);
    // R8 sticky
    cur_req = "R8";
    for (int i = 0; i < 30; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    expect_st("R8", 3, 0);
    // R1 wake mode
    cur_req = "R1";
    do_reset(1'b1, 6);
    expect_st("R1", 0, 1);
    // R7 stop without wake
    cur_req = "R7";
    for (int i = 0; i < 20; i++) step(1, 1, 0);
    expect_st("R7", 0, 1);
    // R3 short wake
    cur_req = "R3";
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    expect_st("R6", 1, 0);
    step(0, 0, 0);
    expect_st("R3", 0, 1);
    // R5 full wake
    cur_req = "R5";
    for (int i = 0; i < 7; i++) step(0, 0, 1);
    expect_st("R5", 2, 0);
    step(1, 1, 1);
    step(0, 0, 0);
    expect_st("R6", 2, 0);
    step(1, 1, 0);
    expect_st("R5", 3, 1);
    cur_req = "R8";
    for (int i = 0; i < 10; i++) step(0, 0, 1);
    expect_st("R8", 3, 1);
    // R10 zero threshold
    cur_req = "R10";
    do_reset(1'b0, 0);
    step(1, 1, 0);
    expect_st("R10", 3, 0);
    // R2 realistic threshold
    cur_req = "R2";
    do_reset(1'b0, 25000);
    for (int i = 0; i < 25000; i++) step(1, 1, 0);
    expect_st("R2", 1, 0);
    step(1, 1, 0);
    expect_st("R2", 3, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule